// File: doc/BRIEF.md
# Circular Store Queue Controller

This block keeps the bookkeeping for a ring of store entries inside an out-of-order core. Dispatch allocates an entry at the tail with the store's sequence number and data. Commit hands over the youngest committed sequence number, and the block walks forward from the oldest entry, flagging every not-yet-flagged store up to that bound as allowed to write back. A conditional store can flag its own entry earlier, as soon as it has executed cleanly. A writeback pointer moves over flagged entries as the memory side takes them, and completions for those issued entries may come back in any order. The head retires a whole run of completed entries in one step.

On a misprediction the block removes the youngest uncommitted entries, walking back from the tail and stopping at the first entry that is already flagged for writeback. The ring has one slot more than its usable capacity, so an empty ring and a full ring never share the same pointer picture. Illegal requests are ignored and raise a sticky error flag. The block also reports how many new memory operations dispatch may send, taking the smaller of the load side's free count and its own.

Top module: `sq_ring_ctrl`

## Requirements
- R1: After reset the ring is empty: head, tail and writeback pointers are 0, no entry is valid, flagged or completed, the flagged-store tally is 0 and the error flag is 0.
- R2: An accepted allocation stores sequence number and data at the tail slot, marks it valid and moves the tail on by one, wrapping from the last slot (index DEPTH) to slot 0. The ring holds at most DEPTH entries in DEPTH+1 slots; full is 1 exactly when tail+1 modulo DEPTH+1 equals head, and an allocation while full is dropped and sets the error flag.
- R3: free_cnt equals the smaller of ld_free and DEPTH minus the number of held entries.
- R4: A commit walks from the head toward the tail; an entry not yet flagged is flagged if its sequence number is not greater than the commit bound, and the walk stops at the first unflagged entry with a greater sequence number. Already flagged entries are passed over.
- R5: A conditional-store request flags the named entry at once if it is valid; on an invalid slot it changes nothing and sets the error flag.
- R6: wb_ok is 1 when the writeback pointer is not at the tail and its entry is flagged, and wb_seq/wb_data then show that entry. An issue request with wb_ok at 1 moves the pointer on by one with wrap; with wb_ok at 0 it is dropped and sets the error flag.
- R7: A completion for an entry between head (inclusive) and the writeback pointer (exclusive) that is not yet completed marks it completed; any other completion is dropped and sets the error flag.
- R8: When the head entry is completed, the head moves over the whole run of consecutive completed entries, freeing each, and stops at the first uncompleted entry or the tail; completions elsewhere leave the head in place.
- R9: A squash walks back from the entry just before the tail, removing each entry whose sequence number is greater than the squash bound and that is not flagged; it stops at the first entry failing either test and the tail moves back over the removed entries.
- R10: In a cycle with a squash request, allocation, commit, conditional-store, issue and completion requests are ignored and raise no error.
- R11: ready_cnt equals the number of valid entries that are flagged for writeback and not yet completed.
- R12: The error flag stays at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate an entry at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_data | input | DATA_W | Data of the new store |
| commit_valid | input | 1 | Commit bound is valid this cycle |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| cond_ready_valid | input | 1 | Conditional store flags its entry early |
| cond_ready_idx | input | PW | Slot of that conditional store |
| issue_valid | input | 1 | Memory side takes the entry at the writeback pointer |
| done_valid | input | 1 | An issued entry has completed |
| done_idx | input | PW | Slot of the completed entry |
| squash_valid | input | 1 | Remove younger uncommitted entries |
| squash_seq | input | SEQ_W | Entries with a greater sequence number are removed |
| ld_free | input | CW | Free count reported by the load side |
| head_idx | output | PW | Oldest slot |
| tail_idx | output | PW | Next slot to allocate |
| wb_idx | output | PW | Writeback pointer |
| used_cnt | output | CW | Entries held |
| free_cnt | output | CW | Operations dispatch may still send |
| full | output | 1 | No slot can be allocated |
| ent_valid | output | SLOTS | Per-slot valid flags |
| ent_ready | output | SLOTS | Per-slot writeback flags |
| ent_done | output | SLOTS | Per-slot completed flags |
| ready_cnt | output | CW | Flagged, uncompleted entries |
| wb_ok | output | 1 | Entry at writeback pointer may be issued |
| wb_seq | output | SEQ_W | Sequence number at writeback pointer |
| wb_data | output | DATA_W | Data at writeback pointer |
| err | output | 1 | Sticky illegal-request flag |

## Verification
The hardest state to reach is an out-of-order completion pattern where several issued entries finish before the head entry, so that a single completion must retire a run that crosses the ring's wrap point, while a squash in the same region must stop at a flagged entry rather than an old one. A directed opening fills the ring, flags entries by both commit and the conditional path, squashes with a competing allocation, and completes issued entries youngest first; a long constrained-random phase then keeps the ring near full with completions drawn from the issued window, so the pointers wrap many times and squashes land among mixed flagged and unflagged entries.

// File: rtl/sq_pkg.sv
`timescale 1ns/1ps
// Ring index helpers shared by the store queue controller.
// Assumes every offset passed in is smaller than the ring size n.
package sq_pkg;

    // Slot reached by moving k places forward from p on a ring of n.
    function automatic int ring_fwd(input int p, input int k, input int n);
        return (p + k) % n;
    endfunction

    // Slot reached by moving k places backward from p on a ring of n.
    function automatic int ring_back(input int p, input int k, input int n);
        return (p - k + n) % n;
    endfunction

    // Forward distance from slot a to slot b on a ring of n.
    function automatic int ring_gap(input int a, input int b, input int n);
        return (b - a + n) % n;
    endfunction

endpackage

// File: rtl/sq_entry_bank.sv
`timescale 1ns/1ps
// Per-slot storage of sequence number and data.
// One write port (allocation) and one read port (writeback pointer);
// all sequence numbers are also exported for the scan logic.
module sq_entry_bank #(
    parameter int SLOTS  = 8,
    parameter int PW     = 3,
    parameter int SEQ_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [PW-1:0]                   wr_idx,
    input  logic [SEQ_W-1:0]                wr_seq,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic [PW-1:0]                   rd_idx,
    output logic [SLOTS-1:0][SEQ_W-1:0]     seqs,
    output logic [DATA_W-1:0]               rd_data
);

    logic [SLOTS-1:0][DATA_W-1:0] data_q;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // Capture the allocating store into its own slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seqs[i]   <= '0;
                data_q[i] <= '0;
            end else if (wr_en && (wr_idx == PW'(i))) begin
                seqs[i]   <= wr_seq;
                data_q[i] <= wr_data;
            end
        end
    end

    // Present the data at the writeback pointer.
    always_comb rd_data = data_q[rd_idx];

endmodule

// File: rtl/sq_commit_scan.sv
`timescale 1ns/1ps
// Commit walk: from the head toward the tail, flags each unflagged entry
// whose sequence number is within the commit bound, and stops at the first
// unflagged entry beyond it. Flagged entries are passed over.
// Assumes sequence numbers grow from head to tail without wrapping.
module sq_commit_scan #(
    parameter int SLOTS = 8,
    parameter int PW    = 3,
    parameter int CW    = 4,
    parameter int SEQ_W = 16
) (
    input  logic                        en,
    input  logic [PW-1:0]               head,
    input  logic [CW-1:0]               count,
    input  logic [SLOTS-1:0]            ready,
    input  logic [SLOTS-1:0][SEQ_W-1:0] seqs,
    input  logic [SEQ_W-1:0]            bound,
    output logic [SLOTS-1:0]            mark
);
    import sq_pkg::*;

    logic          stop;
    logic [PW-1:0] slot;

    // Walk the held entries oldest first and collect the newly flagged ones.
    always_comb begin
        mark = '0;
        stop = 1'b0;
        slot = head;
        for (int k = 0; k < SLOTS; k++) begin
            slot = PW'(ring_fwd(int'(head), k, SLOTS));
            if (en && !stop && (k < int'(count)) && !ready[slot]) begin
                if (seqs[slot] > bound) stop = 1'b1;
                else                    mark[slot] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sq_squash_scan.sv
`timescale 1ns/1ps
// Squash walk: from the entry before the tail backward, selects entries that
// are younger than the bound and not flagged for writeback; stops at the
// first entry failing either test or when all held entries are passed.
module sq_squash_scan #(
    parameter int SLOTS = 8,
    parameter int PW    = 3,
    parameter int CW    = 4,
    parameter int SEQ_W = 16
) (
    input  logic                        en,
    input  logic [PW-1:0]               tail,
    input  logic [CW-1:0]               count,
    input  logic [SLOTS-1:0]            ready,
    input  logic [SLOTS-1:0][SEQ_W-1:0] seqs,
    input  logic [SEQ_W-1:0]            bound,
    output logic [SLOTS-1:0]            rm_mask,
    output logic [CW-1:0]               rm_cnt
);
    import sq_pkg::*;

    logic          stop;
    logic [PW-1:0] slot;

    // Walk youngest first and count the removable run.
    always_comb begin
        rm_mask = '0;
        rm_cnt  = '0;
        stop    = 1'b0;
        slot    = tail;
        for (int k = 1; k < SLOTS; k++) begin
            slot = PW'(ring_back(int'(tail), k, SLOTS));
            if (en && !stop && (k <= int'(count))) begin
                if (!ready[slot] && (seqs[slot] > bound)) begin
                    rm_mask[slot] = 1'b1;
                    rm_cnt        = rm_cnt + CW'(1);
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sq_retire_scan.sv
`timescale 1ns/1ps
// Retire walk: counts the run of completed entries starting at the head,
// bounded by the number of held entries (never passes the tail).
module sq_retire_scan #(
    parameter int SLOTS = 8,
    parameter int PW    = 3,
    parameter int CW    = 4
) (
    input  logic [PW-1:0]    head,
    input  logic [CW-1:0]    count,
    input  logic [SLOTS-1:0] done,
    output logic [SLOTS-1:0] ret_mask,
    output logic [CW-1:0]    ret_cnt
);
    import sq_pkg::*;

    logic          stop;
    logic [PW-1:0] slot;

    // Walk oldest first while entries are completed.
    always_comb begin
        ret_mask = '0;
        ret_cnt  = '0;
        stop     = 1'b0;
        slot     = head;
        for (int k = 0; k < SLOTS; k++) begin
            slot = PW'(ring_fwd(int'(head), k, SLOTS));
            if (!stop && (k < int'(count))) begin
                if (done[slot]) begin
                    ret_mask[slot] = 1'b1;
                    ret_cnt        = ret_cnt + CW'(1);
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sq_ring_ctrl.sv
`timescale 1ns/1ps
// Store queue ring controller.
// Holds DEPTH stores in DEPTH+1 slots (one slot always unused so that an
// empty ring and a full ring differ). Entries are flagged for writeback by
// commit or by a clean conditional store, issued in order by the writeback
// pointer, completed in any order, and retired from the head in runs.
// A squash removes young unflagged entries from the tail and overrides every
// other request of its cycle. Illegal requests are dropped and set a sticky
// error flag. Assumes sequence numbers increase in allocation order and do
// not wrap while entries are held.
module sq_ring_ctrl #(
    parameter  int DEPTH  = 7,
    parameter  int SEQ_W  = 16,
    parameter  int DATA_W = 32,
    localparam int SLOTS  = DEPTH + 1,
    localparam int PW     = $clog2(SLOTS),
    localparam int CW     = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              cond_ready_valid,
    input  logic [PW-1:0]     cond_ready_idx,
    input  logic              issue_valid,
    input  logic              done_valid,
    input  logic [PW-1:0]     done_idx,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic [CW-1:0]     ld_free,
    output logic [PW-1:0]     head_idx,
    output logic [PW-1:0]     tail_idx,
    output logic [PW-1:0]     wb_idx,
    output logic [CW-1:0]     used_cnt,
    output logic [CW-1:0]     free_cnt,
    output logic              full,
    output logic [SLOTS-1:0]  ent_valid,
    output logic [SLOTS-1:0]  ent_ready,
    output logic [SLOTS-1:0]  ent_done,
    output logic [CW-1:0]     ready_cnt,
    output logic              wb_ok,
    output logic [SEQ_W-1:0]  wb_seq,
    output logic [DATA_W-1:0] wb_data,
    output logic              err
);
    import sq_pkg::*;

    // ---------------- state ----------------
    logic [PW-1:0]    head_q, tail_q, wb_q;
    logic [CW-1:0]    cnt_q, rcnt_q;
    logic [SLOTS-1:0] valid_q, ready_q, done_q;
    logic             err_q;

    logic [SLOTS-1:0][SEQ_W-1:0] seqs;

    // ---------------- request qualification ----------------
    logic             live;
    logic             alloc_ok, alloc_bad;
    logic             issue_ok, issue_bad;
    logic             done_ok, done_bad;
    logic             cond_hit, cond_bad;
    logic [SLOTS-1:0] cond_mask, commit_mark, done_mask, alloc_mask;
    logic [SLOTS-1:0] ready_nx, done_nx, new_flags;
    logic [SLOTS-1:0] rm_mask, ret_mask;
    logic [CW-1:0]    rm_cnt, ret_cnt, new_cnt, store_free;
    int               wb_dist, done_dist;

    // A squash cycle shuts out every other request.
    always_comb live = !squash_valid;

    // Ring is full when one more tail step would land on the head.
    always_comb full = (PW'(ring_fwd(int'(tail_q), 1, SLOTS)) == head_q);

    // Writeback pointer may issue when it has not caught the tail and is flagged.
    always_comb wb_ok = (wb_q != tail_q) && ready_q[wb_q];

    // Classify allocation and issue requests.
    always_comb begin
        alloc_ok  = live && alloc_valid && !full;
        alloc_bad = live && alloc_valid && full;
        issue_ok  = live && issue_valid && wb_ok;
        issue_bad = live && issue_valid && !wb_ok;
    end

    // Classify a completion: only issued, not yet completed entries count.
    always_comb begin
        wb_dist   = ring_gap(int'(head_q), int'(wb_q), SLOTS);
        done_dist = ring_gap(int'(head_q), int'(done_idx), SLOTS);
        done_ok   = live && done_valid && (int'(done_idx) < SLOTS) &&
                    (done_dist < wb_dist) && !done_q[done_idx];
        done_bad  = live && done_valid && !done_ok;
        done_mask = '0;
        if (done_ok) done_mask[done_idx] = 1'b1;
    end

    // Classify a conditional-store early flag.
    always_comb begin
        cond_hit  = live && cond_ready_valid && (int'(cond_ready_idx) < SLOTS) &&
                    valid_q[cond_ready_idx];
        cond_bad  = live && cond_ready_valid && !cond_hit;
        cond_mask = '0;
        if (cond_hit) cond_mask[cond_ready_idx] = 1'b1;
    end

    // One-hot of the slot being allocated.
    always_comb begin
        alloc_mask = '0;
        if (alloc_ok) alloc_mask[tail_q] = 1'b1;
    end

    // ---------------- scans ----------------
    sq_commit_scan #(.SLOTS(SLOTS), .PW(PW), .CW(CW), .SEQ_W(SEQ_W)) u_commit (
        .en    (live && commit_valid),
        .head  (head_q),
        .count (cnt_q),
        .ready (ready_q),
        .seqs  (seqs),
        .bound (commit_seq),
        .mark  (commit_mark)
    );

    sq_squash_scan #(.SLOTS(SLOTS), .PW(PW), .CW(CW), .SEQ_W(SEQ_W)) u_squash (
        .en      (squash_valid),
        .tail    (tail_q),
        .count   (cnt_q),
        .ready   (ready_q),
        .seqs    (seqs),
        .bound   (squash_seq),
        .rm_mask (rm_mask),
        .rm_cnt  (rm_cnt)
    );

    // Next flag vectors before retirement, and the count of fresh flags.
    always_comb begin
        ready_nx  = ready_q | commit_mark | cond_mask;
        done_nx   = done_q | done_mask;
        new_flags = (commit_mark | cond_mask) & ~ready_q;
        new_cnt   = CW'($countones(new_flags));
    end

    sq_retire_scan #(.SLOTS(SLOTS), .PW(PW), .CW(CW)) u_retire (
        .head     (head_q),
        .count    (cnt_q),
        .done     (done_nx),
        .ret_mask (ret_mask),
        .ret_cnt  (ret_cnt)
    );

    // ---------------- storage ----------------
    sq_entry_bank #(.SLOTS(SLOTS), .PW(PW), .SEQ_W(SEQ_W), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (alloc_ok),
        .wr_idx  (tail_q),
        .wr_seq  (alloc_seq),
        .wr_data (alloc_data),
        .rd_idx  (wb_q),
        .seqs    (seqs),
        .rd_data (wb_data)
    );

    // ---------------- state update ----------------
    // Pointers, counters and flags: squash path or normal path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            wb_q    <= '0;
            cnt_q   <= '0;
            rcnt_q  <= '0;
            valid_q <= '0;
            ready_q <= '0;
            done_q  <= '0;
            err_q   <= 1'b0;
        end else if (squash_valid) begin
            tail_q  <= PW'(ring_back(int'(tail_q), int'(rm_cnt), SLOTS));
            cnt_q   <= cnt_q - rm_cnt;
            valid_q <= valid_q & ~rm_mask;
            ready_q <= ready_q & ~rm_mask;
            done_q  <= done_q & ~rm_mask;
        end else begin
            head_q  <= PW'(ring_fwd(int'(head_q), int'(ret_cnt), SLOTS));
            tail_q  <= alloc_ok ? PW'(ring_fwd(int'(tail_q), 1, SLOTS)) : tail_q;
            wb_q    <= issue_ok ? PW'(ring_fwd(int'(wb_q), 1, SLOTS)) : wb_q;
            cnt_q   <= cnt_q - ret_cnt + CW'(alloc_ok);
            rcnt_q  <= rcnt_q + new_cnt - CW'(done_ok);
            valid_q <= (valid_q & ~ret_mask) | alloc_mask;
            ready_q <= ready_nx & ~ret_mask;
            done_q  <= done_nx & ~ret_mask;
            err_q   <= err_q | alloc_bad | issue_bad | done_bad | cond_bad;
        end
    end

    // Free count for dispatch: the tighter of the two queues.
    always_comb begin
        store_free = CW'(DEPTH) - cnt_q;
        free_cnt   = (ld_free < store_free) ? ld_free : store_free;
    end

    // Drive the remaining outputs from state.
    always_comb begin
        head_idx  = head_q;
        tail_idx  = tail_q;
        wb_idx    = wb_q;
        used_cnt  = cnt_q;
        ent_valid = valid_q;
        ent_ready = ready_q;
        ent_done  = done_q;
        ready_cnt = rcnt_q;
        wb_seq    = seqs[wb_q];
        err       = err_q;
    end

    // ---------------- assertions ----------------
    assert_tail_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tail_q) == ring_fwd(int'(head_q), int'(cnt_q), SLOTS));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= DEPTH);

    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !squash_valid && full) |=> (cnt_q <= $past(cnt_q)));

    assert_wb_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ring_gap(int'(head_q), int'(wb_q), SLOTS) <= int'(cnt_q));

    assert_head_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> !done_q[head_q]);

    assert_squash_spares_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> (rcnt_q == $past(rcnt_q)) && $stable(head_q) && $stable(wb_q));

    assert_ready_tally_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rcnt_q) == $countones(valid_q & ready_q & ~done_q));

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: tb/tb_sq_ring_ctrl.sv
`timescale 1ns/1ps
module tb_sq_ring_ctrl;

    localparam int DEPTH  = 7;
    localparam int SEQ_W  = 16;
    localparam int DATA_W = 32;
    localparam int SLOTS  = DEPTH + 1;
    localparam int PW     = $clog2(SLOTS);
    localparam int CW     = $clog2(SLOTS + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [SEQ_W-1:0]  alloc_seq = '0;
    logic [DATA_W-1:0] alloc_data = '0;
    logic              commit_valid = 1'b0;
    logic [SEQ_W-1:0]  commit_seq = '0;
    logic              cond_ready_valid = 1'b0;
    logic [PW-1:0]     cond_ready_idx = '0;
    logic              issue_valid = 1'b0;
    logic              done_valid = 1'b0;
    logic [PW-1:0]     done_idx = '0;
    logic              squash_valid = 1'b0;
    logic [SEQ_W-1:0]  squash_seq = '0;
    logic [CW-1:0]     ld_free = '0;
    logic [PW-1:0]     head_idx, tail_idx, wb_idx;
    logic [CW-1:0]     used_cnt, free_cnt, ready_cnt;
    logic              full, wb_ok, err;
    logic [SLOTS-1:0]  ent_valid, ent_ready, ent_done;
    logic [SEQ_W-1:0]  wb_seq;
    logic [DATA_W-1:0] wb_data;

    sq_ring_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_data(alloc_data),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .cond_ready_valid(cond_ready_valid), .cond_ready_idx(cond_ready_idx),
        .issue_valid(issue_valid), .done_valid(done_valid), .done_idx(done_idx),
        .squash_valid(squash_valid), .squash_seq(squash_seq), .ld_free(ld_free),
        .head_idx(head_idx), .tail_idx(tail_idx), .wb_idx(wb_idx),
        .used_cnt(used_cnt), .free_cnt(free_cnt), .full(full),
        .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_done(ent_done),
        .ready_cnt(ready_cnt), .wb_ok(wb_ok), .wb_seq(wb_seq), .wb_data(wb_data),
        .err(err)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // ---------------- reference model ----------------
    int m_seq[$], m_dat[$], m_val[$], m_rdy[$], m_done[$];
    int m_head, m_tail, m_wb, m_cnt, m_rc, m_err;
    int last_seq;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_seq = {}; m_dat = {}; m_val = {}; m_rdy = {}; m_done = {};
        for (int i = 0; i < SLOTS; i++) begin
            m_seq.push_back(0); m_dat.push_back(0); m_val.push_back(0);
            m_rdy.push_back(0); m_done.push_back(0);
        end
        m_head = 0; m_tail = 0; m_wb = 0; m_cnt = 0; m_rc = 0; m_err = 0;
    endtask

    function automatic int m_wb_ok();
        return (m_wb != m_tail && m_rdy[m_wb] != 0) ? 1 : 0;
    endfunction

    // Next state from the requirements, using the inputs now applied.
    task automatic model_step();
        int n, p, wd, cd, marks, a_ok, i_ok, c_ok, s_ok, ci, si;
        int nr[$];
        bit go;
        if (squash_valid) begin
            n = 0; go = 1;
            while (go && n < m_cnt) begin
                p = (m_tail - n - 1 + SLOTS) % SLOTS;
                if (m_rdy[p] == 0 && m_seq[p] > int'(squash_seq)) begin
                    m_val[p] = 0; n++;
                end else go = 0;
            end
            m_tail = (m_tail - n + SLOTS) % SLOTS;
            m_cnt -= n;
            return;
        end
        ci = int'(done_idx); si = int'(cond_ready_idx);
        a_ok = (alloc_valid && m_cnt < DEPTH) ? 1 : 0;
        i_ok = (issue_valid && m_wb_ok() != 0) ? 1 : 0;
        wd = (m_wb - m_head + SLOTS) % SLOTS;
        cd = (ci - m_head + SLOTS) % SLOTS;
        c_ok = (done_valid && cd < wd && m_done[ci] == 0) ? 1 : 0;
        s_ok = (cond_ready_valid && m_val[si] != 0) ? 1 : 0;
        if ((alloc_valid && a_ok == 0) || (issue_valid && i_ok == 0) ||
            (done_valid && c_ok == 0) || (cond_ready_valid && s_ok == 0)) m_err = 1;
        nr = m_rdy;
        if (commit_valid) begin
            for (int k = 0; k < m_cnt; k++) begin
                p = (m_head + k) % SLOTS;
                if (m_rdy[p] == 0) begin
                    if (m_seq[p] > int'(commit_seq)) break;
                    nr[p] = 1;
                end
            end
        end
        if (s_ok != 0) nr[si] = 1;
        marks = 0;
        for (int q = 0; q < SLOTS; q++) if (nr[q] != 0 && m_rdy[q] == 0) marks++;
        m_rdy = nr;
        m_rc += marks;
        if (i_ok != 0) m_wb = (m_wb + 1) % SLOTS;
        if (c_ok != 0) begin m_done[ci] = 1; m_rc--; end
        while (m_cnt > 0 && m_done[m_head] != 0) begin
            m_val[m_head] = 0; m_rdy[m_head] = 0; m_done[m_head] = 0;
            m_head = (m_head + 1) % SLOTS; m_cnt--;
        end
        if (a_ok != 0) begin
            m_val[m_tail] = 1; m_seq[m_tail] = int'(alloc_seq);
            m_dat[m_tail] = int'(alloc_data);
            m_tail = (m_tail + 1) % SLOTS; m_cnt++;
        end
    endtask

    function automatic longint pack(input int v[$]);
        longint r = 0;
        for (int i = 0; i < SLOTS; i++) if (v[i] != 0) r = r | (longint'(1) << i);
        return r;
    endfunction

    // Compare every observable output with the model.
    task automatic compare();
        int ef;
        ef = (int'(ld_free) < DEPTH - m_cnt) ? int'(ld_free) : DEPTH - m_cnt;
        chk("R2 used count", used_cnt, m_cnt);
        chk("R2 tail index", tail_idx, m_tail);
        chk("R2 full flag", full, (m_cnt == DEPTH) ? 1 : 0);
        chk("R2 valid flags", ent_valid, pack(m_val));
        chk("R3 free count", free_cnt, ef);
        chk("R4 writeback flags", ent_ready, pack(m_rdy));
        chk("R6 writeback pointer", wb_idx, m_wb);
        chk("R6 wb_ok", wb_ok, m_wb_ok());
        if (m_wb_ok() != 0) begin
            chk("R6 wb_seq", wb_seq, m_seq[m_wb]);
            chk("R6 wb_data", longint'(wb_data), longint'(unsigned'(m_dat[m_wb])));
        end
        chk("R7 completed flags", ent_done, pack(m_done));
        chk("R8 head index", head_idx, m_head);
        chk("R11 ready tally", ready_cnt, m_rc);
        chk("R12 error flag", err, m_err);
    endtask

    task automatic idle();
        alloc_valid = 0; commit_valid = 0; cond_ready_valid = 0;
        issue_valid = 0; done_valid = 0; squash_valid = 0;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        compare();
    endtask

    task automatic put(input int s);
        alloc_valid = 1; alloc_seq = SEQ_W'(s); alloc_data = DATA_W'(s * 1000 + 7);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected end of stimulus");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int r, wd;
        ld_free = CW'(3);
        @(negedge clk);
        do_reset();
        // R1: empty after reset
        chk("R1 reset head", head_idx, 0);
        chk("R1 reset valid", ent_valid, 0);
        chk("R1 reset error", err, 0);
        chk("R3 free limited by load side", free_cnt, 3);
        ld_free = CW'(15);

        // Fill the ring: seq 10..70 in slots 0..6
        for (int i = 1; i <= DEPTH; i++) begin put(i * 10); tick(); end
        chk("R2 full after DEPTH allocations", full, 1);
        chk("R3 free zero when full", free_cnt, 0);

        commit_valid = 1; commit_seq = SEQ_W'(35); tick();
        chk("R4 commit flags three oldest", ready_cnt, 3);

        cond_ready_valid = 1; cond_ready_idx = PW'(5); tick();
        chk("R5 conditional store flagged early", (ent_ready >> 5) & 1, 1);

        commit_valid = 1; commit_seq = SEQ_W'(45); tick();
        chk("R4 commit passes flagged entries", ent_ready, 8'b0010_1111);

        squash_valid = 1; squash_seq = SEQ_W'(15); put(99); tick();
        chk("R9 squash stops at flagged entry", tail_idx, 6);
        chk("R10 allocation ignored under squash", used_cnt, 6);

        repeat (3) begin issue_valid = 1; tick(); end
        done_valid = 1; done_idx = PW'(2); tick();
        done_valid = 1; done_idx = PW'(1); tick();
        chk("R8 head holds while head entry pending", head_idx, 0);
        done_valid = 1; done_idx = PW'(0); tick();
        chk("R8 head jumps over completed run", head_idx, 3);
        chk("R8 run freed", used_cnt, 3);

        for (int i = 0; i < 4; i++) begin put(100 + i); tick(); end
        chk("R2 tail wrapped", tail_idx, 2);
        put(200); tick();
        chk("R2 allocation dropped when full", used_cnt, DEPTH);
        chk("R12 error raised", err, 1);
        done_valid = 1; done_idx = PW'(4); tick();
        chk("R7 unissued completion ignored", (ent_done >> 4) & 1, 0);
        tick();
        chk("R12 error stays set", err, 1);

        // Constrained-random phase
        do_reset();
        last_seq = 100;
        for (int c = 0; c < 4000; c++) begin
            r = int'($urandom_range(0, 99));
            if (r < 3) begin
                squash_valid = 1;
                squash_seq = SEQ_W'((last_seq > 30) ? last_seq - int'($urandom_range(0, 30)) : 0);
            end
            if (int'($urandom_range(0, 99)) < 60 && m_cnt < DEPTH) begin
                last_seq += int'($urandom_range(1, 3));
                put(last_seq);
            end
            if (int'($urandom_range(0, 99)) < 30) begin
                commit_valid = 1;
                commit_seq = SEQ_W'(last_seq - int'($urandom_range(0, 25)));
            end
            if (m_cnt > 0 && int'($urandom_range(0, 99)) < 6) begin
                cond_ready_valid = 1;
                cond_ready_idx = PW'((m_head + int'($urandom_range(0, m_cnt - 1))) % SLOTS);
            end
            if (m_wb_ok() != 0 && int'($urandom_range(0, 99)) < 45) issue_valid = 1;
            wd = (m_wb - m_head + SLOTS) % SLOTS;
            if (wd > 0 && int'($urandom_range(0, 99)) < 50) begin
                r = (m_head + int'($urandom_range(0, wd - 1))) % SLOTS;
                if (m_done[r] == 0) begin done_valid = 1; done_idx = PW'(r); end
            end
            ld_free = CW'($urandom_range(0, 15));
            tick();
        end
        chk("R12 legal traffic raises no error", err, 0);

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule